// File: doc/BRIEF.md
# Precise Exception Commit Unit

This block follows instructions through a five-stage in-order pipeline. It carries a per-instruction fault code alongside each one and decides, at a single commit point in the memory stage, whether that instruction retires or traps. The four stages each raise a fault of their own: fetch address fault, decode illegal opcode, execute overflow and memory data-address fault. Each fault arrives as a one-cycle pulse that belongs to whatever instruction occupies that stage. The code stays with the instruction until the commit point. There, an external interrupt request can also be injected.

When the commit point traps, the unit records a cause code and the trapping instruction's PC. It also kills every in-flight instruction, steers fetch to a fixed handler address, masks interrupts and enters kernel mode. A return-from-exception pulse unmasks interrupts and returns to user mode. The datapath and memories sit outside the block. Pipeline registers inside the unit carry only a valid bit, a PC and a fault code per stage.

Top module: `exc_commit_unit`

## Requirements
- R1: After reset, cause is 0, epc is 0, kernel_mode is 1, irq_enable is 0, and flush and retire are low.
- R2: An instruction that enters fetch with no fault is presented at the commit point three clock edges later. In that cycle, with no interrupt taken, retire is 1 and flush is 0.
- R3: Cause codes are 3 bits: 0 none, 1 interrupt, 2 fetch fault, 3 illegal opcode, 4 overflow, 5 data fault. A trapping instruction raises flush in its commit cycle. After the next edge, cause holds its code and epc holds that instruction's PC.
- R4: When one instruction collects faults in several stages, the code of the earliest stage is the one recorded.
- R5: An overflow alone records 4, and a data fault raised in the commit cycle alone records 5.
- R6: If ext_irq is high, irq_enable is 1 and the commit point holds a valid instruction, the unit traps with cause 1 and epc is set to that instruction's PC. This overrides any internal fault.
- R7: ext_irq has no effect while irq_enable is 0 or while the commit point holds no valid instruction.
- R8: A flush kills all younger in-flight instructions, so none of them ever retires. redirect_pc equals the HANDLER parameter while flush is high.
- R9: The edge that ends a flush cycle sets kernel_mode to 1 and irq_enable to 0.
- R10: An rfe pulse sets irq_enable to 1 and kernel_mode to 0 at the next edge. If rfe coincides with a flush, the flush wins.
- R11: A fault pulse raised for a stage that holds no valid instruction (a bubble or a killed slot) is ignored.
- R12: cause and epc change only on the edge that ends a flush cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | An instruction occupies fetch this cycle |
| fetch_pc | input | PCW | PC of the instruction in fetch |
| fetch_fault | input | 1 | Fetch address fault for the fetch instruction |
| decode_illegal | input | 1 | Illegal opcode for the decode instruction |
| exec_overflow | input | 1 | Overflow for the execute instruction |
| mem_data_fault | input | 1 | Data address fault for the memory-stage instruction |
| ext_irq | input | 1 | External interrupt request (level) |
| rfe | input | 1 | Return-from-exception pulse |
| flush | output | 1 | Trap taken at commit this cycle; kill all stages |
| redirect_pc | output | PCW | Handler address while flush is high, else 0 |
| retire | output | 1 | Commit-point instruction retires this cycle |
| cause | output | 3 | Recorded cause code |
| epc | output | PCW | Recorded PC of the trapped instruction |
| kernel_mode | output | 1 | 1 in kernel mode |
| irq_enable | output | 1 | Interrupts unmasked |

## Verification
The bench launches each instruction in fetch and applies each stage's fault pulse in the cycle in which the instruction sits in that stage: one, two and three edges later. The combinational results flush, retire and redirect_pc are due in the third cycle after launch, and the bench samples them one nanosecond after driving that cycle's inputs. Cause, epc, kernel_mode and irq_enable are registered, so they are due one edge later and are sampled at the following falling edge. Kill and masking cases hold fault pulses for several empty cycles and sample every one of them.

// File: rtl/exc_pkg.sv
package exc_pkg;
   typedef enum logic [2:0] {
      EXC_NONE    = 3'd0,
      EXC_IRQ     = 3'd1,
      EXC_FETCH   = 3'd2,
      EXC_ILLEGAL = 3'd3,
      EXC_OVF     = 3'd4,
      EXC_DATA    = 3'd5
   } exc_code_t;

   // code tagged by the stage a fault is raised in (0 fetch, 1 decode, 2 execute, 3 memory)
   function automatic exc_code_t stage_tag(input int k);
      case (k)
         0:       return EXC_FETCH;
         1:       return EXC_ILLEGAL;
         2:       return EXC_OVF;
         default: return EXC_DATA;
      endcase
   endfunction
endpackage

// File: rtl/exc_stage.sv
module exc_stage
   import exc_pkg::*;
#(
   parameter int        PCW = 32,
   parameter exc_code_t TAG = EXC_FETCH
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           kill,
   input  logic           in_valid,
   input  logic [PCW-1:0] in_pc,
   input  exc_code_t      in_code,
   input  logic           in_fault,
   output logic           out_valid,
   output logic [PCW-1:0] out_pc,
   output exc_code_t      out_code
);
   exc_code_t nxt_code;

   // an older stage's code is kept; a local fault only tags a clean, valid slot
   always_comb begin
      if (in_code != EXC_NONE)
         nxt_code = in_code;
      else if (in_valid && in_fault)
         nxt_code = TAG;
      else
         nxt_code = EXC_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_pc    <= '0;
         out_code  <= EXC_NONE;
      end else begin
         out_valid <= in_valid && !kill;
         out_pc    <= in_pc;
         out_code  <= kill ? EXC_NONE : nxt_code;
      end
   end
endmodule

// File: rtl/exc_status.sv
module exc_status
   import exc_pkg::*;
#(
   parameter int PCW = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           take,
   input  exc_code_t      take_code,
   input  logic [PCW-1:0] take_pc,
   input  logic           rfe,
   output logic [2:0]     cause,
   output logic [PCW-1:0] epc,
   output logic           kernel_mode,
   output logic           irq_enable
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause       <= 3'd0;
         epc         <= '0;
         kernel_mode <= 1'b1;
         irq_enable  <= 1'b0;
      end else if (take) begin
         cause       <= take_code;
         epc         <= take_pc;
         kernel_mode <= 1'b1;
         irq_enable  <= 1'b0;
      end else if (rfe) begin
         kernel_mode <= 1'b0;
         irq_enable  <= 1'b1;
      end
   end
endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
   import exc_pkg::*;
#(
   parameter int             PCW     = 32,
   parameter logic [PCW-1:0] HANDLER = 'h80
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           fetch_valid,
   input  logic [PCW-1:0] fetch_pc,
   input  logic           fetch_fault,
   input  logic           decode_illegal,
   input  logic           exec_overflow,
   input  logic           mem_data_fault,
   input  logic           ext_irq,
   input  logic           rfe,
   output logic           flush,
   output logic [PCW-1:0] redirect_pc,
   output logic           retire,
   output logic [2:0]     cause,
   output logic [PCW-1:0] epc,
   output logic           kernel_mode,
   output logic           irq_enable
);
   localparam int NSTG = 3;           // registered stages: decode, execute, memory
   localparam int MEM  = NSTG;        // index of the commit slot

   generate
      if (PCW < 2 || PCW > 64) begin : g_bad_pcw
         $error("exc_commit_unit: PCW out of range");
      end
      if (HANDLER[1:0] != 2'b00) begin : g_bad_handler
         $error("exc_commit_unit: HANDLER not word aligned");
      end
   endgenerate

   logic           st_v    [0:NSTG];
   logic [PCW-1:0] st_pc   [0:NSTG];
   exc_code_t      st_code [0:NSTG];
   logic           st_flt  [0:NSTG];

   logic      irq_take;
   exc_code_t m_code;
   exc_code_t take_code;

   assign st_v[0]    = fetch_valid;
   assign st_pc[0]   = fetch_pc;
   assign st_code[0] = EXC_NONE;
   assign st_flt[0]  = fetch_fault;
   assign st_flt[1]  = decode_illegal;
   assign st_flt[2]  = exec_overflow;
   assign st_flt[3]  = mem_data_fault;

   genvar k;
   generate
      for (k = 0; k < NSTG; k++) begin : g_stage
         exc_stage #(
            .PCW (PCW),
            .TAG (stage_tag(k))
         ) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .kill      (flush),
            .in_valid  (st_v[k]),
            .in_pc     (st_pc[k]),
            .in_code   (st_code[k]),
            .in_fault  (st_flt[k]),
            .out_valid (st_v[k+1]),
            .out_pc    (st_pc[k+1]),
            .out_code  (st_code[k+1])
         );
      end
   endgenerate

   // commit point: merge the memory-stage fault, then let an interrupt override
   always_comb begin
      if (st_code[MEM] != EXC_NONE)
         m_code = st_code[MEM];
      else if (st_flt[MEM])
         m_code = stage_tag(MEM);
      else
         m_code = EXC_NONE;
      irq_take  = st_v[MEM] && ext_irq && irq_enable;
      take_code = irq_take ? EXC_IRQ : m_code;
      flush     = st_v[MEM] && (take_code != EXC_NONE);
      retire    = st_v[MEM] && !flush;
   end

   assign redirect_pc = flush ? HANDLER : '0;

   exc_status #(.PCW(PCW)) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .take        (flush),
      .take_code   (take_code),
      .take_pc     (st_pc[MEM]),
      .rfe         (rfe),
      .cause       (cause),
      .epc         (epc),
      .kernel_mode (kernel_mode),
      .irq_enable  (irq_enable)
   );
endmodule

// File: rtl/exc_commit_chk.sv
module exc_commit_chk #(
   parameter int PCW = 32
) (
   input logic           clk,
   input logic           rst_n,
   input logic           flush,
   input logic           retire,
   input logic           ext_irq,
   input logic           rfe,
   input logic           irq_enable,
   input logic           kernel_mode,
   input logic [2:0]     cause,
   input logic [PCW-1:0] epc,
   input logic           v_d,
   input logic           v_x,
   input logic           v_m,
   input logic [PCW-1:0] m_pc
);
   // R2: retire and trap never coincide
   a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(flush && retire));

   // R3: epc captures the PC held at commit
   a_r3_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> epc == $past(m_pc));

   // R6: an unmasked interrupt at commit records cause 1
   a_r6_irq_first: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && ext_irq && irq_enable) |=> cause == 3'd1);

   // R8: every stage is empty after a flush
   a_r8_pipe_empty: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!v_d && !v_x && !v_m));

   // R9: trap enters kernel mode with interrupts masked
   a_r9_enter_kernel: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (kernel_mode && !irq_enable));

   // R10: return from exception unmasks and leaves kernel mode
   a_r10_rfe: assert property (@(posedge clk) disable iff (!rst_n)
      (rfe && !flush) |=> (irq_enable && !kernel_mode));

   // R11: an empty commit slot neither traps nor retires
   a_r11_empty_slot: assert property (@(posedge clk) disable iff (!rst_n)
      !v_m |-> (!flush && !retire));

   // R12: recorded state holds outside trap cycles
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> ($stable(cause) && $stable(epc)));
endmodule

bind exc_commit_unit exc_commit_chk #(.PCW(PCW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flush       (flush),
   .retire      (retire),
   .ext_irq     (ext_irq),
   .rfe         (rfe),
   .irq_enable  (irq_enable),
   .kernel_mode (kernel_mode),
   .cause       (cause),
   .epc         (epc),
   .v_d         (st_v[1]),
   .v_x         (st_v[2]),
   .v_m         (st_v[3]),
   .m_pc        (st_pc[3])
);

// File: tb/exc_commit_unit_bench.sv
module exc_commit_unit_bench;
   localparam int             PCW     = 32;
   localparam logic [PCW-1:0] HANDLER = 32'h80;
   localparam int             NVEC    = 11;

   // vector: {fetch_fault, decode_illegal, exec_overflow, mem_data_fault, ext_irq, code[2:0]}
   localparam logic [7:0] VEC [0:NVEC-1] = '{
      8'b00000_000,  // R2 clean
      8'b10000_010,  // R3 fetch fault
      8'b01000_011,  // R3 illegal
      8'b00100_100,  // R5 overflow
      8'b00010_101,  // R5 data fault
      8'b10110_010,  // R4 fetch beats overflow and data
      8'b01100_011,  // R4 illegal beats overflow
      8'b00110_100,  // R4 overflow beats data
      8'b00001_001,  // R6 interrupt
      8'b01011_001,  // R6 interrupt beats illegal and data
      8'b00000_000   // R12 clean, state held
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           fetch_valid = 1'b0;
   logic [PCW-1:0] fetch_pc = '0;
   logic           fetch_fault = 1'b0;
   logic           decode_illegal = 1'b0;
   logic           exec_overflow = 1'b0;
   logic           mem_data_fault = 1'b0;
   logic           ext_irq = 1'b0;
   logic           rfe = 1'b0;
   logic           flush;
   logic [PCW-1:0] redirect_pc;
   logic           retire;
   logic [2:0]     cause;
   logic [PCW-1:0] epc;
   logic           kernel_mode;
   logic           irq_enable;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   exc_commit_unit #(.PCW(PCW), .HANDLER(HANDLER)) u_exc_commit_unit (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [2:0]     exp_cause;
      logic [PCW-1:0] exp_epc;
      exp_cause = 3'd0;
      exp_epc   = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 cause", cause, 0);
      chk("R1 epc", epc, 0);
      chk("R1 kernel", kernel_mode, 1);
      chk("R1 irqen", irq_enable, 0);
      chk("R1 flush", flush, 0);
      chk("R1 retire", retire, 0);

      for (int i = 0; i < NVEC; i++) begin
         logic [7:0]     v;
         logic [PCW-1:0] pc;
         logic           trap;
         v    = VEC[i];
         pc   = 32'h100 + 32'(4 * i);
         trap = (v[2:0] != 3'd0);
         // launch in fetch; rfe while commit slot is empty
         fetch_valid = 1'b1; fetch_pc = pc; fetch_fault = v[7]; rfe = 1'b1;
         @(negedge clk);
         fetch_valid = 1'b0; fetch_fault = 1'b0; rfe = 1'b0; decode_illegal = v[6];
         @(negedge clk);
         decode_illegal = 1'b0; exec_overflow = v[5];
         @(negedge clk);
         exec_overflow = 1'b0; mem_data_fault = v[4]; ext_irq = v[3];
         #1;
         chk("R2/R3 flush at commit", flush, trap);
         chk("R2 retire at commit", retire, !trap);
         if (trap) chk("R8 redirect", redirect_pc, HANDLER);
         @(negedge clk);
         mem_data_fault = 1'b0; ext_irq = 1'b0;
         if (trap) begin
            exp_cause = v[2:0];
            exp_epc   = pc;
         end
         chk("R3/R4/R5/R6/R12 cause", cause, exp_cause);
         chk("R3/R12 epc", epc, exp_epc);
         chk("R9/R10 kernel", kernel_mode, trap);
         chk("R9/R10 irqen", irq_enable, !trap);
      end

      // R10: rfe together with a trap -> trap wins
      fetch_valid = 1'b1; fetch_pc = 32'h300;
      @(negedge clk);
      fetch_valid = 1'b0;
      @(negedge clk);
      exec_overflow = 1'b1;
      @(negedge clk);
      exec_overflow = 1'b0; rfe = 1'b1;
      #1 chk("R10 flush with rfe", flush, 1);
      @(negedge clk);
      rfe = 1'b0;
      chk("R10 kernel kept", kernel_mode, 1);
      chk("R10 irqen kept", irq_enable, 0);
      chk("R5 overflow cause", cause, 4);

      // R7: masked interrupt ignored at commit
      fetch_valid = 1'b1; fetch_pc = 32'h310; ext_irq = 1'b1;
      @(negedge clk);
      fetch_valid = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      chk("R7 masked no flush", flush, 0);
      chk("R7 masked retire", retire, 1);
      @(negedge clk);
      chk("R7 cause held", cause, 4);
      chk("R7 epc held", epc, 32'h300);

      // R7/R10: rfe with interrupt pending and empty pipeline
      rfe = 1'b1;
      @(negedge clk);
      rfe = 1'b0;
      chk("R10 irqen set", irq_enable, 1);
      chk("R10 user mode", kernel_mode, 0);
      #1 chk("R7 empty slot no flush", flush, 0);
      @(negedge clk);
      ext_irq = 1'b0;
      chk("R7 cause unchanged", cause, 4);

      // R8/R11: back-to-back A(overflow), B, C; B and C killed
      fetch_valid = 1'b1; fetch_pc = 32'h200;
      @(negedge clk);
      fetch_pc = 32'h204;
      @(negedge clk);
      fetch_pc = 32'h208; exec_overflow = 1'b1;
      @(negedge clk);
      fetch_valid = 1'b0; exec_overflow = 1'b0;
      #1;
      chk("R8 flush for A", flush, 1);
      chk("R8 redirect handler", redirect_pc, HANDLER);
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         rfe = (c == 0); decode_illegal = 1'b1; exec_overflow = 1'b1;
         mem_data_fault = 1'b1; ext_irq = 1'b1;
         #1;
         chk("R8/R11 killed no retire", retire, 0);
         chk("R11 killed no flush", flush, 0);
      end
      @(negedge clk);
      rfe = 1'b0; decode_illegal = 1'b0; exec_overflow = 1'b0;
      mem_data_fault = 1'b0; ext_irq = 1'b0;
      chk("R11 cause kept", cause, 4);
      chk("R11 epc kept", epc, 32'h200);

      finish_run();
   end
endmodule